// File: doc/BRIEF.md
# Display Instruction Decoder and Address Counter

This block sits behind the serial receiver of a character LCD controller. Each time a frame has been shifted in and committed, the receiver presents it as a 64-bit word whose bit k holds transfer bit Dk, together with a length code. The decoder reads a 4-bit opcode from the word and updates the controller's configuration. That configuration covers the drive technique, a per-digit enable mask, the main/accessory display selects, a blanking flag and a power-save flag. The decoder also keeps one shared address counter, made of a 6-bit character-RAM address and a 4-bit accessory-RAM address. For the character RAM, the accessory RAM and the glyph RAM it issues one-cycle write requests. The memories and the panel scan are built elsewhere.

Writes to the character and accessory RAMs can open a streaming sub-mode. After the first write, short 8-bit frames deliver consecutive data bytes, and a 16-bit frame closes the stream. While the stream is open, every other instruction is locked out. Each accepted instruction keeps the decoder busy for a fixed number of display-clock ticks. Frames that arrive during that window are discarded and recorded in a sticky flag. Entering power save does not start that window. While power save is on, only the on/off instruction is decoded.

Top module: `lcd_instr_decoder`

## Requirements
- R1: After reset: disp_mode is 0 (1/8 duty), digit_mask is 0, show_main, show_acc, blank and power_save are 0, both address fields are 0, busy, overflow and inc_active are 0, and no write strobe is high.
- R2: The opcode nibble is {D60,D61,D62,D63}. Its values are: 0001 technique, 0010 on/off, 0011 shift, 0100 set address, 0101 character write, 0110 accessory write, 0111 glyph write. The technique instruction loads disp_mode from {D57,D56}, with 0 = 1/8, 1 = 1/9 and 2 = 1/10 duty. Code 3 leaves disp_mode unchanged.
- R3: The on/off instruction loads digit_mask[i] from D(40+i) for the 12 digits, show_main from D56, show_acc from D57, blank from D58 and power_save from D59.
- R4: The set-address instruction loads char_addr from D48..D53 (D48 is the LSB) and acc_addr from D56..D59 (D56 is the LSB).
- R5: A character write with D56=0 raises char_we for exactly one cycle. It carries the data from D40..D47 and the address from D48..D53. The address counter is not changed. An accessory write does the same on acc_we, with data from D40..D44 and address from D48..D51.
- R6: A glyph write raises glyph_we for one cycle. It carries the 45-bit pattern from D0..D44 and the address from D48..D55.
- R7: A character or accessory write with D56=1 writes at the address given in the frame and sets inc_active. Each following 8-bit frame writes the next address, one higher and wrapping after 47 (character) or 11 (accessory). Character data comes from D56..D63 and accessory data from D56..D60.
- R8: A 16-bit frame that has D56=0 and the same write opcode writes its data to the next address and clears inc_active. Character data comes from D48..D55 and accessory data from D48..D52.
- R9: While inc_active is 1, full frames have no effect on the configuration, the address counter or any write strobe.
- R10: A shift with D58=0 adds one to the selected address fields, and a shift with D58=1 subtracts one. char_addr wraps modulo 48 and acc_addr wraps modulo 12. D56 selects char_addr and D57 selects acc_addr.
- R11: While power_save is 1, every frame except a full on/off frame is ignored. An on/off frame that sets power_save leaves busy low.
- R12: Any other accepted instruction holds busy high for 8 tick pulses. A frame that arrives while busy is high is dropped and sets overflow, which stays set until reset.
- R13: Outside the streaming sub-mode, short frames and frames with opcodes 0000 or 1xxx are ignored and do not start the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per display-clock period |
| frame_valid | input | 1 | Committed frame present this cycle |
| frame_len | input | 2 | 0 = full frame, 1 = 8-bit frame, 2 = 16-bit frame |
| frame_data | input | 64 | Frame word, bit k = Dk |
| busy | output | 1 | Execution window active |
| overflow | output | 1 | Sticky: a frame was dropped while busy |
| inc_active | output | 1 | Streaming write sub-mode open |
| disp_mode | output | 2 | Drive technique code |
| digit_mask | output | 12 | Per-digit enable |
| show_main | output | 1 | Character data shown |
| show_acc | output | 1 | Accessory data shown |
| blank | output | 1 | Drivers forced to ground level |
| power_save | output | 1 | Power-save state |
| char_addr | output | 6 | Counter character-RAM address |
| acc_addr | output | 4 | Counter accessory-RAM address |
| char_we | output | 1 | Character RAM write strobe |
| char_waddr | output | 6 | Character RAM write address |
| char_wdata | output | 8 | Character code |
| acc_we | output | 1 | Accessory RAM write strobe |
| acc_waddr | output | 4 | Accessory RAM write address |
| acc_wdata | output | 5 | Accessory segment bits |
| glyph_we | output | 1 | Glyph RAM write strobe |
| glyph_waddr | output | 8 | Glyph RAM write address |
| glyph_wdata | output | 45 | Glyph pattern |

## Verification
The bench builds the decoder with its default parameters. Depths of 48 and 12 are not powers of two, so both address steppers use the compare-and-wrap variant. This lets the streaming and shift tests cross the 47-to-0 and 11-to-0 boundaries in both directions. The busy window of 8 ticks, with a tick on every fourth clock, lasts about 32 cycles. That makes it easy to land a second frame inside the window and to measure when the window closes.

// File: rtl/lcd_instr_pkg.sv
package lcd_instr_pkg;

   localparam logic [3:0] OP_TECH   = 4'b0001;
   localparam logic [3:0] OP_ONOFF  = 4'b0010;
   localparam logic [3:0] OP_SHIFT  = 4'b0011;
   localparam logic [3:0] OP_SETAC  = 4'b0100;
   localparam logic [3:0] OP_WCHAR  = 4'b0101;
   localparam logic [3:0] OP_WACC   = 4'b0110;
   localparam logic [3:0] OP_WGLYPH = 4'b0111;

   localparam logic [1:0] FL_FULL = 2'd0;
   localparam logic [1:0] FL_BYTE = 2'd1;
   localparam logic [1:0] FL_HALF = 2'd2;

   typedef enum logic [1:0] {
      INC_NONE = 2'd0,
      INC_CHAR = 2'd1,
      INC_ACC  = 2'd2
   } inc_kind_e;

endpackage

// File: rtl/lcd_frame_fields.sv
module lcd_frame_fields #(
   parameter int DIGITS   = 12,
   parameter int CHAR_AW  = 6,
   parameter int CHAR_DW  = 8,
   parameter int ACC_AW   = 4,
   parameter int ACC_DW   = 5,
   parameter int GLYPH_AW = 8,
   parameter int GLYPH_DW = 45
) (
   input  logic [63:0]          d,
   output logic [3:0]           op,
   output logic [1:0]           tech,
   output logic [DIGITS-1:0]    mask,
   output logic                 b56,
   output logic                 b57,
   output logic                 b58,
   output logic                 b59,
   output logic [CHAR_AW-1:0]   set_char,
   output logic [ACC_AW-1:0]    set_acc,
   output logic [CHAR_DW-1:0]   wr_char_data,
   output logic [CHAR_AW-1:0]   wr_char_addr,
   output logic [ACC_DW-1:0]    wr_acc_data,
   output logic [ACC_AW-1:0]    wr_acc_addr,
   output logic [CHAR_DW-1:0]   byte_char,
   output logic [ACC_DW-1:0]    byte_acc,
   output logic [CHAR_DW-1:0]   half_char,
   output logic [ACC_DW-1:0]    half_acc,
   output logic [GLYPH_DW-1:0]  glyph_data,
   output logic [GLYPH_AW-1:0]  glyph_addr
);

   initial begin
      assert (40 + DIGITS <= 56) else $error("digit mask overruns control bits");
      assert (48 + CHAR_AW <= 56) else $error("character address too wide");
      assert (56 + ACC_AW <= 60) else $error("accessory address too wide");
      assert (56 + CHAR_DW <= 64) else $error("character data too wide");
      assert (GLYPH_DW <= 48 && 48 + GLYPH_AW <= 60) else $error("glyph fields overlap");
   end

   always_comb begin
      op           = {d[60], d[61], d[62], d[63]};
      tech         = d[57:56];
      mask         = d[40 +: DIGITS];
      b56          = d[56];
      b57          = d[57];
      b58          = d[58];
      b59          = d[59];
      set_char     = d[48 +: CHAR_AW];
      set_acc      = d[56 +: ACC_AW];
      wr_char_data = d[40 +: CHAR_DW];
      wr_char_addr = d[48 +: CHAR_AW];
      wr_acc_data  = d[40 +: ACC_DW];
      wr_acc_addr  = d[48 +: ACC_AW];
      byte_char    = d[56 +: CHAR_DW];
      byte_acc     = d[56 +: ACC_DW];
      half_char    = d[48 +: CHAR_DW];
      half_acc     = d[48 +: ACC_DW];
      glyph_data   = d[0 +: GLYPH_DW];
      glyph_addr   = d[48 +: GLYPH_AW];
   end

endmodule

// File: rtl/lcd_addr_step.sv
module lcd_addr_step #(
   parameter int DEPTH = 48,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cur,
   input  logic          up,
   input  logic          down,
   output logic [AW-1:0] nxt
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam bit            POW2 = (DEPTH == (1 << AW));

   initial begin
      assert (DEPTH >= 2 && DEPTH <= (1 << AW)) else $error("depth does not fit address width");
   end

   generate
      if (POW2) begin : g_pow2
         always_comb begin
            if (up)        nxt = cur + 1'b1;
            else if (down) nxt = cur - 1'b1;
            else           nxt = cur;
         end
      end else begin : g_cmp
         always_comb begin
            if (up)        nxt = (cur >= LAST) ? '0 : cur + 1'b1;
            else if (down) nxt = (cur == '0) ? LAST : cur - 1'b1;
            else           nxt = cur;
         end
      end
   endgenerate

   // R10: a step from an in-range address stays in range
   a_r10_wrap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ((up || down) && cur <= LAST) |-> (nxt <= LAST));

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
   parameter int TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic busy
);

   generate
      if (TICKS == 0) begin : g_none
         assign busy = 1'b0;
      end else begin : g_count
         localparam int BW = $clog2(TICKS + 1);
         logic [BW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt <= '0;
            else if (start)             cnt <= BW'(TICKS);
            else if (tick && cnt != '0) cnt <= cnt - 1'b1;
         end

         assign busy = (cnt != '0);

         // R12: window opens after a start and cannot close without a tick
         a_r12_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> busy);
         a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !tick) |=> busy);
      end
   endgenerate

endmodule

// File: rtl/lcd_instr_decoder.sv
module lcd_instr_decoder
   import lcd_instr_pkg::*;
#(
   parameter int DIGITS     = 12,
   parameter int CHAR_DEPTH = 48,
   parameter int CHAR_AW    = 6,
   parameter int CHAR_DW    = 8,
   parameter int ACC_DEPTH  = 12,
   parameter int ACC_AW     = 4,
   parameter int ACC_DW     = 5,
   parameter int GLYPH_AW   = 8,
   parameter int GLYPH_DW   = 45,
   parameter int BUSY_TICKS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 frame_valid,
   input  logic [1:0]           frame_len,
   input  logic [63:0]          frame_data,
   output logic                 busy,
   output logic                 overflow,
   output logic                 inc_active,
   output logic [1:0]           disp_mode,
   output logic [DIGITS-1:0]    digit_mask,
   output logic                 show_main,
   output logic                 show_acc,
   output logic                 blank,
   output logic                 power_save,
   output logic [CHAR_AW-1:0]   char_addr,
   output logic [ACC_AW-1:0]    acc_addr,
   output logic                 char_we,
   output logic [CHAR_AW-1:0]   char_waddr,
   output logic [CHAR_DW-1:0]   char_wdata,
   output logic                 acc_we,
   output logic [ACC_AW-1:0]    acc_waddr,
   output logic [ACC_DW-1:0]    acc_wdata,
   output logic                 glyph_we,
   output logic [GLYPH_AW-1:0]  glyph_waddr,
   output logic [GLYPH_DW-1:0]  glyph_wdata
);

   localparam logic [1:0] TECH_RSVD = 2'd3;

   // ---------------- field extraction ----------------
   logic [3:0]          f_op;
   logic [1:0]          f_tech;
   logic [DIGITS-1:0]   f_mask;
   logic                f_b56, f_b57, f_b58, f_b59;
   logic [CHAR_AW-1:0]  f_set_char, f_wr_char_addr;
   logic [ACC_AW-1:0]   f_set_acc, f_wr_acc_addr;
   logic [CHAR_DW-1:0]  f_wr_char_data, f_byte_char, f_half_char;
   logic [ACC_DW-1:0]   f_wr_acc_data, f_byte_acc, f_half_acc;
   logic [GLYPH_DW-1:0] f_glyph_data;
   logic [GLYPH_AW-1:0] f_glyph_addr;

   lcd_frame_fields #(
      .DIGITS(DIGITS), .CHAR_AW(CHAR_AW), .CHAR_DW(CHAR_DW),
      .ACC_AW(ACC_AW), .ACC_DW(ACC_DW),
      .GLYPH_AW(GLYPH_AW), .GLYPH_DW(GLYPH_DW)
   ) u_fields (
      .d(frame_data), .op(f_op), .tech(f_tech), .mask(f_mask),
      .b56(f_b56), .b57(f_b57), .b58(f_b58), .b59(f_b59),
      .set_char(f_set_char), .set_acc(f_set_acc),
      .wr_char_data(f_wr_char_data), .wr_char_addr(f_wr_char_addr),
      .wr_acc_data(f_wr_acc_data), .wr_acc_addr(f_wr_acc_addr),
      .byte_char(f_byte_char), .byte_acc(f_byte_acc),
      .half_char(f_half_char), .half_acc(f_half_acc),
      .glyph_data(f_glyph_data), .glyph_addr(f_glyph_addr)
   );

   // ---------------- state ----------------
   inc_kind_e          inc_kind;
   logic [CHAR_AW-1:0] inc_char_ptr;
   logic [ACC_AW-1:0]  inc_acc_ptr;

   logic in_inc, is_full, is_byte, is_half;
   logic [3:0] inc_op;

   assign in_inc  = (inc_kind != INC_NONE);
   assign is_full = (frame_len == FL_FULL);
   assign is_byte = (frame_len == FL_BYTE);
   assign is_half = (frame_len == FL_HALF);
   assign inc_op  = (inc_kind == INC_CHAR) ? OP_WCHAR : OP_WACC;

   // ---------------- instruction classification ----------------
   logic do_tech, do_onoff, do_shift, do_setac;
   logic do_wchar, do_wacc, do_wglyph, do_ibyte, do_iterm;
   logic legal, go, enter_ps;

   always_comb begin
      do_tech   = 1'b0;
      do_onoff  = 1'b0;
      do_shift  = 1'b0;
      do_setac  = 1'b0;
      do_wchar  = 1'b0;
      do_wacc   = 1'b0;
      do_wglyph = 1'b0;
      do_ibyte  = 1'b0;
      do_iterm  = 1'b0;
      if (in_inc) begin
         if (is_byte)                                  do_ibyte = 1'b1;
         else if (is_half && !f_b56 && f_op == inc_op) do_iterm = 1'b1;
      end else if (is_full) begin
         if (power_save) begin
            do_onoff = (f_op == OP_ONOFF);
         end else begin
            case (f_op)
               OP_TECH:   do_tech   = 1'b1;
               OP_ONOFF:  do_onoff  = 1'b1;
               OP_SHIFT:  do_shift  = 1'b1;
               OP_SETAC:  do_setac  = 1'b1;
               OP_WCHAR:  do_wchar  = 1'b1;
               OP_WACC:   do_wacc   = 1'b1;
               OP_WGLYPH: do_wglyph = 1'b1;
               default:   ;
            endcase
         end
      end
   end

   assign legal    = do_tech | do_onoff | do_shift | do_setac | do_wchar |
                     do_wacc | do_wglyph | do_ibyte | do_iterm;
   assign go       = frame_valid && !busy && legal;
   assign enter_ps = do_onoff && f_b59;

   // ---------------- address steppers ----------------
   logic [CHAR_AW-1:0] char_src, char_shift_nxt, char_inc_nxt;
   logic [ACC_AW-1:0]  acc_src, acc_shift_nxt, acc_inc_nxt;

   assign char_src = in_inc ? inc_char_ptr : f_wr_char_addr;
   assign acc_src  = in_inc ? inc_acc_ptr  : f_wr_acc_addr;

   lcd_addr_step #(.DEPTH(CHAR_DEPTH), .AW(CHAR_AW)) u_char_shift (
      .clk(clk), .rst_n(rst_n), .cur(char_addr),
      .up(!f_b58), .down(f_b58), .nxt(char_shift_nxt));

   lcd_addr_step #(.DEPTH(ACC_DEPTH), .AW(ACC_AW)) u_acc_shift (
      .clk(clk), .rst_n(rst_n), .cur(acc_addr),
      .up(!f_b58), .down(f_b58), .nxt(acc_shift_nxt));

   lcd_addr_step #(.DEPTH(CHAR_DEPTH), .AW(CHAR_AW)) u_char_inc (
      .clk(clk), .rst_n(rst_n), .cur(char_src),
      .up(1'b1), .down(1'b0), .nxt(char_inc_nxt));

   lcd_addr_step #(.DEPTH(ACC_DEPTH), .AW(ACC_AW)) u_acc_inc (
      .clk(clk), .rst_n(rst_n), .cur(acc_src),
      .up(1'b1), .down(1'b0), .nxt(acc_inc_nxt));

   // ---------------- busy window ----------------
   lcd_busy_timer #(.TICKS(BUSY_TICKS)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(go && !enter_ps),
      .tick(tick), .busy(busy));

   // ---------------- state update ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_mode    <= '0;
         digit_mask   <= '0;
         show_main    <= 1'b0;
         show_acc     <= 1'b0;
         blank        <= 1'b0;
         power_save   <= 1'b0;
         char_addr    <= '0;
         acc_addr     <= '0;
         inc_kind     <= INC_NONE;
         inc_char_ptr <= '0;
         inc_acc_ptr  <= '0;
         overflow     <= 1'b0;
         char_we      <= 1'b0;
         char_waddr   <= '0;
         char_wdata   <= '0;
         acc_we       <= 1'b0;
         acc_waddr    <= '0;
         acc_wdata    <= '0;
         glyph_we     <= 1'b0;
         glyph_waddr  <= '0;
         glyph_wdata  <= '0;
      end else begin
         char_we  <= 1'b0;
         acc_we   <= 1'b0;
         glyph_we <= 1'b0;
         if (frame_valid && busy) overflow <= 1'b1;
         if (go) begin
            if (do_tech && f_tech != TECH_RSVD) disp_mode <= f_tech;
            if (do_onoff) begin
               digit_mask <= f_mask;
               show_main  <= f_b56;
               show_acc   <= f_b57;
               blank      <= f_b58;
               power_save <= f_b59;
            end
            if (do_shift) begin
               if (f_b56) char_addr <= char_shift_nxt;
               if (f_b57) acc_addr  <= acc_shift_nxt;
            end
            if (do_setac) begin
               char_addr <= f_set_char;
               acc_addr  <= f_set_acc;
            end
            if (do_wchar) begin
               char_we    <= 1'b1;
               char_waddr <= char_src;
               char_wdata <= f_wr_char_data;
               if (f_b56) begin
                  inc_kind     <= INC_CHAR;
                  inc_char_ptr <= char_inc_nxt;
               end
            end
            if (do_wacc) begin
               acc_we    <= 1'b1;
               acc_waddr <= acc_src;
               acc_wdata <= f_wr_acc_data;
               if (f_b56) begin
                  inc_kind    <= INC_ACC;
                  inc_acc_ptr <= acc_inc_nxt;
               end
            end
            if (do_wglyph) begin
               glyph_we    <= 1'b1;
               glyph_waddr <= f_glyph_addr;
               glyph_wdata <= f_glyph_data;
            end
            if (do_ibyte || do_iterm) begin
               if (inc_kind == INC_CHAR) begin
                  char_we      <= 1'b1;
                  char_waddr   <= char_src;
                  char_wdata   <= do_ibyte ? f_byte_char : f_half_char;
                  inc_char_ptr <= char_inc_nxt;
               end else begin
                  acc_we      <= 1'b1;
                  acc_waddr   <= acc_src;
                  acc_wdata   <= do_ibyte ? f_byte_acc : f_half_acc;
                  inc_acc_ptr <= acc_inc_nxt;
               end
               if (do_iterm) inc_kind <= INC_NONE;
            end
         end
      end
   end

   assign inc_active = in_inc;

   // ---------------- assertions ----------------
   a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({char_we, acc_we, glyph_we}));

   a_r12_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_valid) |=> !(char_we || acc_we || glyph_we));

   a_r12_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   a_r11_ps_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      (power_save && frame_valid && !(is_full && f_op == OP_ONOFF))
      |=> ($stable(char_addr) && $stable(acc_addr) && $stable(disp_mode)
           && !char_we && !acc_we && !glyph_we));

   a_r11_ps_no_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(power_save) |-> !busy);

   a_r9_inc_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_active && frame_valid && is_full)
      |=> ($stable(char_addr) && $stable(acc_addr) && $stable(digit_mask)
           && !char_we && !acc_we && !glyph_we));

   a_r13_short_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_active && frame_valid && !is_full) |=> !(char_we || acc_we));

endmodule

// File: tb/lcd_instr_decoder_tb.sv
module lcd_instr_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        frame_valid = 1'b0;
   logic [1:0]  frame_len = 2'd0;
   logic [63:0] frame_data = '0;

   logic        busy, overflow, inc_active;
   logic [1:0]  disp_mode;
   logic [11:0] digit_mask;
   logic        show_main, show_acc, blank, power_save;
   logic [5:0]  char_addr;
   logic [3:0]  acc_addr;
   logic        char_we;
   logic [5:0]  char_waddr;
   logic [7:0]  char_wdata;
   logic        acc_we;
   logic [3:0]  acc_waddr;
   logic [4:0]  acc_wdata;
   logic        glyph_we;
   logic [7:0]  glyph_waddr;
   logic [44:0] glyph_wdata;

   lcd_instr_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .frame_valid(frame_valid),
      .frame_len(frame_len), .frame_data(frame_data), .busy(busy),
      .overflow(overflow), .inc_active(inc_active), .disp_mode(disp_mode),
      .digit_mask(digit_mask), .show_main(show_main), .show_acc(show_acc),
      .blank(blank), .power_save(power_save), .char_addr(char_addr),
      .acc_addr(acc_addr), .char_we(char_we), .char_waddr(char_waddr),
      .char_wdata(char_wdata), .acc_we(acc_we), .acc_waddr(acc_waddr),
      .acc_wdata(acc_wdata), .glyph_we(glyph_we), .glyph_waddr(glyph_waddr),
      .glyph_wdata(glyph_wdata));

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          kind;   // 0 char, 1 acc, 2 glyph
      logic [7:0]  addr;
      logic [44:0] data;
      string       tag;
   } wr_item_t;

   wr_item_t exp_q[$];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_wr(input int kind, input logic [7:0] addr,
                            input logic [44:0] data, input string tag);
      wr_item_t it;
      it.kind = kind; it.addr = addr; it.data = data; it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: pops and compares each write strobe
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (char_we || acc_we || glyph_we)) begin
            int          k;
            logic [7:0]  a;
            logic [44:0] dt;
            k  = char_we ? 0 : (acc_we ? 1 : 2);
            a  = char_we ? {2'b0, char_waddr} : (acc_we ? {4'b0, acc_waddr} : glyph_waddr);
            dt = char_we ? {37'b0, char_wdata} : (acc_we ? {40'b0, acc_wdata} : glyph_wdata);
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R5 unexpected write: actual kind=%0d addr=%0h data=%0h expected none",
                        k, a, dt);
            end else begin
               wr_item_t e;
               e = exp_q.pop_front();
               if (k != e.kind || a !== e.addr || dt !== e.data) begin
                  errors++;
                  $display("FAIL %s write: actual kind=%0d addr=%0h data=%0h expected kind=%0d addr=%0h data=%0h",
                           e.tag, k, a, dt, e.kind, e.addr, e.data);
               end
            end
         end
      end
   end

   // display-clock tick every fourth cycle
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   // frame builders
   function automatic logic [63:0] fop(input logic [3:0] op);
      logic [63:0] d = '0;
      d[60] = op[3]; d[61] = op[2]; d[62] = op[1]; d[63] = op[0];
      return d;
   endfunction
   function automatic logic [63:0] fr_tech(input logic [1:0] c);
      logic [63:0] d = fop(4'b0001); d[57:56] = c; return d;
   endfunction
   function automatic logic [63:0] fr_onoff(input logic [11:0] m, input logic sm,
                                            input logic sa, input logic sc, input logic ps);
      logic [63:0] d = fop(4'b0010);
      d[51:40] = m; d[56] = sm; d[57] = sa; d[58] = sc; d[59] = ps; return d;
   endfunction
   function automatic logic [63:0] fr_shift(input logic m, input logic a, input logic rl);
      logic [63:0] d = fop(4'b0011); d[56] = m; d[57] = a; d[58] = rl; return d;
   endfunction
   function automatic logic [63:0] fr_setac(input logic [5:0] c, input logic [3:0] a);
      logic [63:0] d = fop(4'b0100); d[53:48] = c; d[59:56] = a; return d;
   endfunction
   function automatic logic [63:0] fr_wchar(input logic [7:0] v, input logic [5:0] a, input logic im);
      logic [63:0] d = fop(4'b0101); d[47:40] = v; d[53:48] = a; d[56] = im; return d;
   endfunction
   function automatic logic [63:0] fr_wacc(input logic [4:0] v, input logic [3:0] a, input logic im);
      logic [63:0] d = fop(4'b0110); d[44:40] = v; d[51:48] = a; d[56] = im; return d;
   endfunction
   function automatic logic [63:0] fr_wglyph(input logic [44:0] p, input logic [7:0] a);
      logic [63:0] d = fop(4'b0111); d[44:0] = p; d[55:48] = a; return d;
   endfunction

   task automatic send(input logic [1:0] len, input logic [63:0] d);
      @(negedge clk);
      while (busy) @(negedge clk);
      frame_len = len; frame_data = d; frame_valid = 1'b1;
      @(negedge clk);
      frame_valid = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mode", disp_mode, 0);
      chk("R1 mask", digit_mask, 0);
      chk("R1 flags", {show_main, show_acc, blank, power_save}, 0);
      chk("R1 addr", {char_addr, acc_addr}, 0);
      chk("R1 busy/ovf/inc", {busy, overflow, inc_active}, 0);
      chk("R1 strobes", {char_we, acc_we, glyph_we}, 0);

      // R2 technique
      send(2'd0, fr_tech(2'd1)); chk("R2 1/9", disp_mode, 1);
      send(2'd0, fr_tech(2'd2)); chk("R2 1/10", disp_mode, 2);
      send(2'd0, fr_tech(2'd3)); chk("R2 reserved kept", disp_mode, 2);

      // R3 on/off
      send(2'd0, fr_onoff(12'hABC, 1'b1, 1'b0, 1'b1, 1'b0));
      chk("R3 mask", digit_mask, 12'hABC);
      chk("R3 flags", {show_main, show_acc, blank, power_save}, 4'b1010);

      // R12 window length
      n = 0;
      while (busy && n < 100) begin @(negedge clk); n++; end
      checks++;
      if (n < 27 || n > 33) begin
         errors++;
         $display("FAIL R12 busy length: actual=%0d expected=27..33", n);
      end

      // R4 set address
      send(2'd0, fr_setac(6'd46, 4'd10));
      chk("R4 addr", {char_addr, acc_addr}, {6'd46, 4'd10});

      // R10 shifts
      send(2'd0, fr_shift(1, 1, 0)); chk("R10 left both", {char_addr, acc_addr}, {6'd47, 4'd11});
      send(2'd0, fr_shift(1, 1, 0)); chk("R10 left wrap", {char_addr, acc_addr}, {6'd0, 4'd0});
      send(2'd0, fr_shift(1, 0, 1)); chk("R10 right main", {char_addr, acc_addr}, {6'd47, 4'd0});
      send(2'd0, fr_shift(0, 1, 1)); chk("R10 right acc", {char_addr, acc_addr}, {6'd47, 4'd11});
      send(2'd0, fr_shift(0, 0, 1)); chk("R10 none", {char_addr, acc_addr}, {6'd47, 4'd11});

      // R5 normal writes
      expect_wr(0, 8'h10, 45'h5A, "R5 char");
      send(2'd0, fr_wchar(8'h5A, 6'h10, 1'b0));
      chk("R5 counter kept", char_addr, 6'd47);
      chk("R5 no inc", inc_active, 0);
      expect_wr(1, 8'h3, 45'h15, "R5 acc");
      send(2'd0, fr_wacc(5'h15, 4'd3, 1'b0));

      // R6 glyph
      expect_wr(2, 8'h0F, 45'h1BCD_EF01_2345, "R6 glyph");
      send(2'd0, fr_wglyph(45'h1BCD_EF01_2345, 8'h0F));

      // R7 / R8 / R9 character stream
      expect_wr(0, 8'd46, 45'h41, "R7 first");
      send(2'd0, fr_wchar(8'h41, 6'd46, 1'b1));
      chk("R7 inc set", inc_active, 1);
      expect_wr(0, 8'd47, 45'h42, "R7 next");
      send(2'd1, {8'h42, 56'h0});
      send(2'd0, fr_setac(6'd5, 4'd5));
      chk("R9 addr kept", {char_addr, acc_addr}, {6'd47, 4'd11});
      chk("R9 still inc", inc_active, 1);
      expect_wr(0, 8'd0, 45'h43, "R7 wrap");
      send(2'd1, {8'h43, 56'h0});
      expect_wr(0, 8'd1, 45'h44, "R8 term");
      begin
         logic [63:0] t = fop(4'b0101);
         t[55:48] = 8'h44;
         send(2'd2, t);
      end
      chk("R8 inc cleared", inc_active, 0);

      // R13 short frame outside the stream
      send(2'd1, {8'h99, 56'h0});
      chk("R13 short busy", busy, 0);

      // accessory stream
      expect_wr(1, 8'd11, 45'h01, "R7 acc first");
      send(2'd0, fr_wacc(5'h01, 4'd11, 1'b1));
      expect_wr(1, 8'd0, 45'h02, "R7 acc wrap");
      send(2'd1, {3'b0, 5'h02, 56'h0});
      expect_wr(1, 8'd1, 45'h1F, "R8 acc term");
      begin
         logic [63:0] t = fop(4'b0110);
         t[52:48] = 5'h1F;
         send(2'd2, t);
      end
      chk("R8 acc cleared", inc_active, 0);

      // R13 unknown opcodes
      send(2'd0, fop(4'b0000) | 64'h00FF_FFFF_FFFF);
      chk("R13 op0 busy", busy, 0);
      send(2'd0, fop(4'b1010) | fr_setac(6'd3, 4'd3));
      chk("R13 op1xxx busy", busy, 0);
      chk("R13 state kept", {char_addr, acc_addr, disp_mode}, {6'd47, 4'd11, 2'd2});

      // R12 drop during busy
      chk("R12 no overflow yet", overflow, 0);
      expect_wr(0, 8'd5, 45'h77, "R12 first");
      @(negedge clk);
      while (busy) @(negedge clk);
      frame_len = 2'd0; frame_data = fr_wchar(8'h77, 6'd5, 1'b0); frame_valid = 1'b1;
      @(negedge clk);
      frame_data = fr_wchar(8'h66, 6'd6, 1'b0);
      @(negedge clk);
      frame_valid = 1'b0;
      chk("R12 busy", busy, 1);
      chk("R12 overflow", overflow, 1);

      // R11 power save
      send(2'd0, fr_onoff(12'h000, 0, 0, 0, 1));
      chk("R11 ps set", power_save, 1);
      chk("R11 no window", busy, 0);
      send(2'd0, fr_setac(6'd5, 4'd5));
      send(2'd0, fr_wchar(8'h12, 6'd2, 1'b0));
      send(2'd0, fr_tech(2'd0));
      chk("R11 locked", {char_addr, acc_addr, disp_mode}, {6'd47, 4'd11, 2'd2});
      send(2'd0, fr_onoff(12'hFFF, 1, 1, 0, 0));
      chk("R11 ps cleared", power_save, 0);
      chk("R3 mask all", digit_mask, 12'hFFF);
      chk("R12 overflow sticky", overflow, 1);

      repeat (40) @(negedge clk);
      chk("R5 all writes seen", exp_q.size(), 0);
      done = 1'b1;
      summary();
   end

endmodule